// File: doc/BRIEF.md
# Receive-Level Software Flow Pacer

This block watches how full a receive FIFO is and keeps the far-end sender from overrunning it. It sends software pause characters when the level climbs to a high-water mark and resume characters when host reads drain it to a low-water mark. Both marks come packed in one flow-level word. The gap between the two marks is the hysteresis. A stored paused flag records whether the far end has been told to stop. Because of that flag, each crossing produces exactly one control sequence.

A sequence is one character or two, chosen by a two-bit mode field. The block offers each character to the local transmitter through a valid/ready pair. The transmitter raises ready only at a free word slot, ahead of its own queued data. A word that is already being sent is therefore never cut short.

A sequence that has started always runs to its end before the level is looked at again. If the level swings back while a sequence is waiting, the opposite sequence follows only after the first one has finished.

Top module: `rxf_flow_pacer`

## Requirements
- R1: While reset is high and on the first cycle after it, `ins_valid` and `paused` are both 0. After reset the block is not paused.
- R2: `flow_mode` selects the behaviour. 2'b00 means off, and no character is ever offered. 2'b01 means single-character sequences using `xoff_a`/`xon_a`. 2'b10 means single-character sequences using `xoff_b`/`xon_b`. 2'b11 means two-character sequences.
- R3: When the block is idle, enabled and not paused, and `fill_lvl` >= the high-water mark, then at the next edge `ins_valid` rises with the first pause character and `paused` becomes 1.
- R4: When the block is idle, enabled and paused, and `fill_lvl` <= the low-water mark, then at the next edge `ins_valid` rises with the first resume character and `paused` becomes 0.
- R5: In mode 2'b11, `xoff_a` is offered before `xoff_b` and `xon_a` before `xon_b`. The second character is offered on the edge that accepts the first one.
- R6: Each crossing produces exactly one sequence. A level that stays at or above the high-water mark, or at or below the low-water mark, adds no further characters.
- R7: A character is consumed only on an edge where `ins_valid` and `ins_ready` are both 1. While `ins_ready` is 0, the offered character and `ins_valid` hold.
- R8: A pending sequence completes before the opposite sequence is queued. The opposite sequence is queued at the first idle cycle where its condition holds, and `paused` does not change while a sequence is pending.
- R9: The flow-level word carries the high-water mark in bits [2*CNT_W-1:CNT_W] and the low-water mark in bits [CNT_W-1:0].
- R10: Setting the mode to 2'b00 while paused clears `paused` once the block is idle. No resume character is sent in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flow_mode | input | 2 | Flow-control mode field |
| flow_word | input | 2*CNT_W | Packed high-water (upper) and low-water (lower) marks |
| fill_lvl | input | CNT_W | Current receive FIFO fill count |
| xon_a | input | CHAR_W | First resume character |
| xon_b | input | CHAR_W | Second resume character |
| xoff_a | input | CHAR_W | First pause character |
| xoff_b | input | CHAR_W | Second pause character |
| ins_ready | input | 1 | Transmitter has a free word slot and takes the offered character |
| ins_valid | output | 1 | A control character is offered |
| ins_char | output | CHAR_W | Offered control character |
| paused | output | 1 | Far end has been told to pause |

## Verification
The bench sweeps every mode and every legal pair of marks on a 4-bit fill count. It ramps the level up through the high-water mark and back down through the low-water mark, and compares the exact character stream with an expected stream. A design that re-fired while dwelling past a mark, swapped first and second characters, or compared with the wrong inequality would produce the wrong stream. Directed cases stall the transmitter while the level reverses, checking that a held character neither changes nor gets skipped and that the resume sequence waits. A further case checks that disabling while paused clears the flag silently instead of emitting a resume character.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    FLOW_OFF    = 2'b00,
    FLOW_FIRST  = 2'b01,
    FLOW_SECOND = 2'b10,
    FLOW_BOTH   = 2'b11
  } flow_mode_e;

  typedef enum logic {
    SEQ_RESUME = 1'b0,
    SEQ_PAUSE  = 1'b1
  } seq_kind_e;
endpackage

// File: rtl/rxf_level_cmp.sv
module rxf_level_cmp #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]   fill_lvl,
  input  logic [2*CNT_W-1:0] flow_word,
  output logic               at_high,
  output logic               at_low
);
  logic [CNT_W-1:0] high_mark;
  logic [CNT_W-1:0] low_mark;

  // R9: upper half is the high-water mark, lower half the low-water mark
  assign high_mark = flow_word[2*CNT_W-1:CNT_W];
  assign low_mark  = flow_word[CNT_W-1:0];

  always_comb begin
    at_high = (fill_lvl >= high_mark);
    at_low  = (fill_lvl <= low_mark);
  end
endmodule

// File: rtl/rxf_pause_track.sv
module rxf_pause_track
  import rxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enabled,
  input  logic      busy,
  input  logic      at_high,
  input  logic      at_low,
  output logic      paused,
  output logic      start,
  output seq_kind_e start_kind
);
  logic paused_q;

  always_comb begin
    start      = 1'b0;
    start_kind = SEQ_RESUME;
    if (enabled && !busy) begin
      if (!paused_q && at_high) begin
        start      = 1'b1;
        start_kind = SEQ_PAUSE;
      end else if (paused_q && at_low) begin
        start      = 1'b1;
        start_kind = SEQ_RESUME;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paused_q <= 1'b0;
    end else if (start) begin
      paused_q <= (start_kind == SEQ_PAUSE);
    end else if (!enabled && !busy) begin
      paused_q <= 1'b0;
    end
  end

  assign paused = paused_q;

  AST_PAUSE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(paused_q) |-> $past(at_high)); // R3
  AST_STEADY_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(paused_q)); // R8
endmodule

// File: rtl/rxf_seq_emit.sv
module rxf_seq_emit
  import rxf_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  seq_kind_e         start_kind,
  input  flow_mode_e        mode,
  input  logic [CHAR_W-1:0] xon_a,
  input  logic [CHAR_W-1:0] xon_b,
  input  logic [CHAR_W-1:0] xoff_a,
  input  logic [CHAR_W-1:0] xoff_b,
  input  logic              ins_ready,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_char,
  output logic              busy
);
  logic              valid_q;
  logic [CHAR_W-1:0] char_q;
  logic              second_left;
  seq_kind_e         kind_q;
  logic [CHAR_W-1:0] first_pick;
  logic [CHAR_W-1:0] second_pick;

  always_comb begin
    if (mode == FLOW_SECOND)
      first_pick = (start_kind == SEQ_PAUSE) ? xoff_b : xon_b;
    else
      first_pick = (start_kind == SEQ_PAUSE) ? xoff_a : xon_a;
    second_pick = (kind_q == SEQ_PAUSE) ? xoff_b : xon_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      char_q      <= '0;
      second_left <= 1'b0;
      kind_q      <= SEQ_RESUME;
    end else if (!valid_q) begin
      if (start) begin
        valid_q     <= 1'b1;
        char_q      <= first_pick;
        kind_q      <= start_kind;
        second_left <= (mode == FLOW_BOTH);
      end
    end else if (ins_ready) begin
      if (second_left) begin
        char_q      <= second_pick;
        second_left <= 1'b0;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign ins_valid = valid_q;
  assign ins_char  = char_q;
  assign busy      = valid_q;

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ins_ready) |=> (valid_q && $stable(char_q))); // R7
  AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ins_ready && second_left) |=> (valid_q && !second_left)); // R5
endmodule

// File: rtl/rxf_flow_pacer.sv
module rxf_flow_pacer
  import rxf_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int CHAR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         flow_mode,
  input  logic [2*CNT_W-1:0] flow_word,
  input  logic [CNT_W-1:0]   fill_lvl,
  input  logic [CHAR_W-1:0]  xon_a,
  input  logic [CHAR_W-1:0]  xon_b,
  input  logic [CHAR_W-1:0]  xoff_a,
  input  logic [CHAR_W-1:0]  xoff_b,
  input  logic               ins_ready,
  output logic               ins_valid,
  output logic [CHAR_W-1:0]  ins_char,
  output logic               paused
);
  flow_mode_e mode;
  logic       enabled;
  logic       at_high;
  logic       at_low;
  logic       busy;
  logic       start;
  seq_kind_e  start_kind;

  assign mode    = flow_mode_e'(flow_mode);
  assign enabled = (mode != FLOW_OFF);

  rxf_level_cmp #(.CNT_W(CNT_W)) u_cmp (
    .fill_lvl  (fill_lvl),
    .flow_word (flow_word),
    .at_high   (at_high),
    .at_low    (at_low)
  );

  rxf_pause_track u_track (
    .clk        (clk),
    .rst        (rst),
    .enabled    (enabled),
    .busy       (busy),
    .at_high    (at_high),
    .at_low     (at_low),
    .paused     (paused),
    .start      (start),
    .start_kind (start_kind)
  );

  rxf_seq_emit #(.CHAR_W(CHAR_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_kind (start_kind),
    .mode       (mode),
    .xon_a      (xon_a),
    .xon_b      (xon_b),
    .xoff_a     (xoff_a),
    .xoff_b     (xoff_b),
    .ins_ready  (ins_ready),
    .ins_valid  (ins_valid),
    .ins_char   (ins_char),
    .busy       (busy)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!ins_valid && !paused)); // R1
  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(ins_valid) |-> ($past(flow_mode) != 2'b00)); // R2
  AST_RESUME_SENDS: assert property (@(posedge clk) disable iff (rst)
    ($fell(paused) && ($past(flow_mode) != 2'b00)) |-> ins_valid); // R4
  AST_SILENT_DISABLE: assert property (@(posedge clk) disable iff (rst)
    ($fell(paused) && ($past(flow_mode) == 2'b00)) |-> !ins_valid); // R10
endmodule

// File: tb/rxf_flow_pacer_bench.sv
module rxf_flow_pacer_bench;
  localparam int CNT_W  = 4;
  localparam int CHAR_W = 8;
  localparam logic [7:0] XON_A  = 8'h11;
  localparam logic [7:0] XON_B  = 8'h91;
  localparam logic [7:0] XOFF_A = 8'h13;
  localparam logic [7:0] XOFF_B = 8'h93;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         flow_mode = 2'b00;
  logic [2*CNT_W-1:0] flow_word = '0;
  logic [CNT_W-1:0]   fill_lvl = '0;
  logic               ins_ready = 1'b1;
  logic               ins_valid;
  logic [CHAR_W-1:0]  ins_char;
  logic               paused;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] got [0:63];
  int         got_n = 0;

  always #5 clk = ~clk;

  rxf_flow_pacer #(.CNT_W(CNT_W), .CHAR_W(CHAR_W)) u_rxf_flow_pacer (
    .clk       (clk),
    .rst       (rst),
    .flow_mode (flow_mode),
    .flow_word (flow_word),
    .fill_lvl  (fill_lvl),
    .xon_a     (XON_A),
    .xon_b     (XON_B),
    .xoff_a    (XOFF_A),
    .xoff_b    (XOFF_B),
    .ins_ready (ins_ready),
    .ins_valid (ins_valid),
    .ins_char  (ins_char),
    .paused    (paused)
  );

  always @(negedge clk) begin
    if (!rst && ins_valid && ins_ready) begin
      got[got_n % 64] = ins_char;
      got_n = got_n + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] first_of(input int m, input bit pause);
    if (m == 2) return pause ? XOFF_B : XON_B;
    return pause ? XOFF_A : XON_A;
  endfunction

  // Full ramp up and down under one configuration; checks stream and flag (R2 R3 R4 R5 R6 R9)
  task automatic run_cfg(input int m, input int h, input int r);
    int base;
    int len;
    int k;
    logic [7:0] exp_s [0:3];
    flow_mode = m[1:0];
    flow_word = {h[CNT_W-1:0], r[CNT_W-1:0]};
    fill_lvl  = '0;
    ins_ready = 1'b1;
    tick(2);
    base = got_n;
    len  = (m == 0) ? 0 : ((m == 3) ? 2 : 1);
    k = 0;
    if (len > 0) begin
      exp_s[k] = first_of(m, 1'b1); k++;
      if (len == 2) begin exp_s[k] = XOFF_B; k++; end
      exp_s[k] = first_of(m, 1'b0); k++;
      if (len == 2) begin exp_s[k] = XON_B; k++; end
    end
    for (int v = 0; v < 16; v++) begin
      fill_lvl = v[CNT_W-1:0];
      tick(4);
    end
    chk(paused == (m != 0), "R3 paused after rise", paused, (m != 0));
    chk((got_n - base) == len, "R6 one pause sequence", got_n - base, len);
    for (int v = 15; v >= 0; v--) begin
      fill_lvl = v[CNT_W-1:0];
      tick(4);
    end
    chk(paused == 1'b0, "R4 resumed after fall", paused, 0);
    chk((got_n - base) == 2 * len, "R2 R6 stream length", got_n - base, 2 * len);
    for (int i = 0; i < 2 * len; i++)
      chk(got[(base + i) % 64] == exp_s[i], "R5 R9 stream order", got[(base + i) % 64], exp_s[i]);
  endtask

  initial begin
    int base;
    // R1: reset holds everything idle even with a triggering level
    flow_mode = 2'b11;
    flow_word = {4'd2, 4'd0};
    fill_lvl  = 4'd15;
    tick(3);
    chk(!ins_valid, "R1 no request in reset", ins_valid, 0);
    chk(!paused, "R1 not paused in reset", paused, 0);
    rst = 1'b0;
    chk(!ins_valid && !paused, "R1 idle on release", {ins_valid, paused}, 0);
    tick(1);
    chk(ins_valid && ins_char == XOFF_A, "R3 first edge after reset", ins_char, XOFF_A);
    tick(4);
    fill_lvl = 4'd0;
    tick(6);

    // Exhaustive sweep of modes and mark pairs
    for (int m = 0; m < 4; m++)
      for (int h = 1; h < 16; h++)
        for (int r = 0; r < h; r++)
          run_cfg(m, h, r);

    // R7 R8: stall the transmitter while the level reverses
    flow_mode = 2'b11;
    flow_word = {4'd8, 4'd3};
    fill_lvl  = 4'd0;
    ins_ready = 1'b0;
    tick(3);
    base = got_n;
    fill_lvl = 4'd9;
    tick(1);
    chk(ins_valid && ins_char == XOFF_A, "R3 pause offered", ins_char, XOFF_A);
    tick(3);
    chk(ins_valid && ins_char == XOFF_A, "R7 held while stalled", ins_char, XOFF_A);
    fill_lvl = 4'd0;
    tick(2);
    chk(paused == 1'b1, "R8 flag steady while pending", paused, 1);
    chk(ins_char == XOFF_A, "R8 pending not replaced", ins_char, XOFF_A);
    ins_ready = 1'b1;
    tick(1);
    chk(ins_valid && ins_char == XOFF_B, "R5 second after accept", ins_char, XOFF_B);
    tick(1);
    chk(!ins_valid, "R8 gap before opposite", ins_valid, 0);
    tick(1);
    chk(ins_valid && ins_char == XON_A && !paused, "R8 resume queued after", ins_char, XON_A);
    tick(4);
    chk((got_n - base) == 4, "R8 stream length", got_n - base, 4);
    chk(got[(base + 2) % 64] == XON_A && got[(base + 3) % 64] == XON_B,
        "R8 resume follows pause", got[(base + 3) % 64], XON_B);

    // R10: disable while paused clears flag silently
    flow_mode = 2'b01;
    flow_word = {4'd8, 4'd2};
    fill_lvl  = 4'd10;
    tick(5);
    chk(paused == 1'b1, "R3 paused before disable", paused, 1);
    base = got_n;
    flow_mode = 2'b00;
    tick(1);
    chk(paused == 1'b0, "R10 flag cleared", paused, 0);
    tick(5);
    chk(got_n == base && !ins_valid, "R10 no resume sent", got_n - base, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule